// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control and status register file of a DMA engine with up to 64 channels. It keeps four per-channel bit vectors: hardware-request enables, error-interrupt enables, interrupt-pending flags and error-pending flags. Each vector is split across a high word (channels 63..32) and a low word (channels 31..0). Software can write the enable words whole, or change a single channel's bit by writing that channel's number to a byte-wide command register. Pending words are write-one-to-clear.

The transfer engine reports per-channel completion and error events as one-cycle pulses. The bank records them and drives a done interrupt and an error interrupt. It also latches one error status word that holds the first error seen, and gives the engine per-channel start and done-clear pulses. Reads are combinational from a word index. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `dma_chan_regbank`

## Requirements
- R1: After a synchronous active-low reset every readable word is zero. `irq_done`, `irq_err`, `ch_start`, `ch_done_clr` and `req_en` are all zero.
- R2: Word index 0 (byte offset 0x00) is the control word. Only bit 31 (clock gating enable), bit 3 (round-robin group) and bit 2 (round-robin channel) are stored; other bits read zero. The enable words are at index 2/3 (request enable high/low) and 4/5 (error-interrupt enable high/low). All of these honour the byte strobes, with `bus_be[k]` covering `bus_wdata[8k+7:8k]`.
- R3: Index 6 holds four command bytes: set request enable (lane 0), clear request enable (lane 1), set error-interrupt enable (lane 2) and clear error-interrupt enable (lane 3). Writing channel number n in a lane changes bit n only.
- R4: A command byte whose bit 6 or bit 7 is set, or whose value is not below NUM_CH, has no effect.
- R5: A pulse on `ch_done_evt[n]` sets interrupt-pending bit n; these bits are readable at index 8 (high) and 9 (low). Writing a 1 to a bit of those words clears that bit. The index 7 lane 0 command clears one channel's bit. `irq_done` is high while any interrupt-pending bit is set.
- R6: A pulse on `ch_err_evt[n]` sets error-pending bit n; these bits are readable at index 10 (high) and 11 (low). Writing a 1 to a bit of those words clears that bit. The index 7 lane 1 command clears one channel's bit.
- R7: When a set event and a clear (command or write-one) hit the same pending bit in the same cycle, the bit ends up set.
- R8: The error status word is at index 1. Its layout is: bit 31 valid, bit 15 group priority error, bit 14 channel priority error, bits 13:8 failing channel, bits 7:0 cause. The layout of `err_info` is {group, channel, cause[7:0]}. The word is loaded only when valid is clear, and it takes the lowest-numbered channel that reported an error in that cycle. Writing bit 31 as 1 under `bus_be[3]` clears the word.
- R9: `irq_err` is high exactly while some channel has both its error-pending bit and its error-interrupt-enable bit set.
- R10: A set-start command (index 7 lane 2) gives a one-cycle pulse on `ch_start[n]` in the cycle after the write. A clear-done command (index 7 lane 3) does the same on `ch_done_clr[n]`.
- R11: The command words (index 6 and 7) and all indices from 12 upward read as zero.
- R12: `req_en` presents the request-enable bits, channel n on bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | 6 | Word index (byte offset / 4) for reads and writes |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_waddr` |
| ch_done_evt | input | NUM_CH | Per-channel completion pulses |
| ch_err_evt | input | NUM_CH | Per-channel error pulses |
| err_info | input | 10 | Error qualifiers that go with `ch_err_evt` |
| irq_done | output | 1 | Any interrupt-pending bit set |
| irq_err | output | 1 | Enabled error pending |
| req_en | output | NUM_CH | Hardware request enables |
| ch_start | output | NUM_CH | One-cycle start pulses |
| ch_done_clr | output | NUM_CH | One-cycle done-clear pulses |
| ctl_clk_gate_en | output | 1 | Control bit 31 |
| ctl_rr_group | output | 1 | Control bit 3 |
| ctl_rr_chan | output | 1 | Control bit 2 |

## Verification
The bench uses the default NUM_CH of 64, so both halves of every split word are fully populated. With that value, channel 63 sits at the top bit of each high word. The ignore rule for command bytes is then reached only through bits 6 and 7, which the bench drives directly. Errors at channels 40, 2, 5 and 9 exercise the first-error hold and the lowest-channel pick across both words.

// File: rtl/dma_regbank_pkg.sv
// Package: shared offsets, command lane numbers and error status layout
// for the DMA channel control register bank. Word indices are byte
// offsets divided by four.
package dma_regbank_pkg;

    localparam int unsigned WI_CTRL    = 0;
    localparam int unsigned WI_ESTAT   = 1;
    localparam int unsigned WI_REQ_HI  = 2;
    localparam int unsigned WI_REQ_LO  = 3;
    localparam int unsigned WI_EEI_HI  = 4;
    localparam int unsigned WI_EEI_LO  = 5;
    localparam int unsigned WI_CMD_A   = 6;
    localparam int unsigned WI_CMD_B   = 7;
    localparam int unsigned WI_INT_HI  = 8;
    localparam int unsigned WI_INT_LO  = 9;
    localparam int unsigned WI_ERR_HI  = 10;
    localparam int unsigned WI_ERR_LO  = 11;

    // Command byte numbers: lanes 0..3 of WI_CMD_A, then of WI_CMD_B.
    localparam int unsigned N_CMD         = 8;
    localparam int unsigned CMD_SET_REQ   = 0;
    localparam int unsigned CMD_CLR_REQ   = 1;
    localparam int unsigned CMD_SET_EEI   = 2;
    localparam int unsigned CMD_CLR_EEI   = 3;
    localparam int unsigned CMD_CLR_INT   = 4;
    localparam int unsigned CMD_CLR_ERR   = 5;
    localparam int unsigned CMD_SET_START = 6;
    localparam int unsigned CMD_CLR_DONE  = 7;

    // Control word bit positions.
    localparam int unsigned CTL_CLKGATE_BIT = 31;
    localparam int unsigned CTL_RRGRP_BIT   = 3;
    localparam int unsigned CTL_RRCH_BIT    = 2;

    // Error status layout.
    localparam int unsigned ES_VALID_BIT = 31;
    localparam int unsigned ES_GRP_BIT   = 15;
    localparam int unsigned ES_CHP_BIT   = 14;
    localparam int unsigned ES_CH_LSB    = 8;
    localparam int unsigned CH_IDX_W     = 6;
    localparam int unsigned MAX_CH       = 64;

    typedef struct packed {
        logic       grp_prio;
        logic       chan_prio;
        logic [7:0] cause;
    } err_info_t;

    // Pick the high or low 32-bit half of a padded 64-bit channel vector.
    function automatic logic [31:0] half_of(input logic [63:0] v, input logic hi);
        return hi ? v[63:32] : v[31:0];
    endfunction

    // Expand four byte strobes into a 32-bit lane mask.
    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

endpackage

// File: rtl/dma_cmd_decode.sv
// Module: dma_cmd_decode
// Turns writes to the two command words into per-command one-hot
// channel vectors. Each byte lane carries one command; the value is a
// channel number. Assumes values with bit 6 or 7 set, or not below
// NUM_CH, must have no effect.
module dma_cmd_decode
    import dma_regbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic [5:0]                       waddr,
    input  logic [3:0]                       be,
    input  logic [31:0]                      wdata,
    output logic [N_CMD-1:0][NUM_CH-1:0]     cmd_hit
);

    for (genvar k = 0; k < N_CMD; k++) begin : g_cmd
        localparam int unsigned LANE = k % 4;
        localparam int unsigned WIDX = (k < 4) ? WI_CMD_A : WI_CMD_B;

        logic       lane_sel;
        logic [7:0] val;
        logic       val_ok;

        // Purpose: qualify this command byte and check its channel value.
        always_comb begin
            lane_sel = wr && (waddr == 6'(WIDX)) && be[LANE];
            val      = wdata[8*LANE +: 8];
            val_ok   = (val[7:6] == 2'b00) && (32'(val[5:0]) < NUM_CH);
        end

        for (genvar j = 0; j < NUM_CH; j++) begin : g_ch
            // Purpose: one channel's match for this command.
            always_comb cmd_hit[k][j] = lane_sel && val_ok && (val[5:0] == 6'(j));
        end

        // R4: a command byte with a high bit set never selects a channel.
        p_cmd_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_sel && (val[7:6] != 2'b00)) |-> (cmd_hit[k] == '0));
    end

endmodule

// File: rtl/dma_chan_bits.sv
// Module: dma_chan_bits
// A vector of per-channel flag bits with word load, clear and set.
// Precedence per bit: load, then clear, then set (set wins over clear).
// Assumes load_en, clr and set come from decoded bus writes and events.
module dma_chan_bits #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: update one flag bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else
                q[i] <= ((load_en[i] ? load_val[i] : q[i]) & ~clr[i]) | set[i];
        end
    end

    // R7: any bit set in a cycle reads as one in the next.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((q & $past(set)) == $past(set)));

endmodule

// File: rtl/dma_err_capture.sv
// Module: dma_err_capture
// Holds the error status word. Loads valid, qualifiers and the lowest
// reporting channel only while the word is not valid, so the first
// error is kept until software clears it by writing one to bit 31.
module dma_err_capture
    import dma_regbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] err_evt,
    input  logic [9:0]        info,
    input  logic              clr,
    output logic [31:0]       status
);

    err_info_t             info_s;
    logic [CH_IDX_W-1:0]   first_ch;
    logic                  any_err;
    logic [31:0]           next_word;

    // Purpose: find the lowest-numbered channel reporting an error.
    always_comb begin
        first_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (err_evt[i]) first_ch = CH_IDX_W'(i);
        end
        any_err = |err_evt;
    end

    // Purpose: assemble the status word to load.
    always_comb begin
        info_s    = err_info_t'(info);
        next_word = '0;
        next_word[ES_VALID_BIT]                  = 1'b1;
        next_word[ES_GRP_BIT]                    = info_s.grp_prio;
        next_word[ES_CHP_BIT]                    = info_s.chan_prio;
        next_word[ES_CH_LSB +: CH_IDX_W]         = first_ch;
        next_word[7:0]                           = info_s.cause;
    end

    // Purpose: capture first error, clear on request (a new error wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else if (any_err && (!status[ES_VALID_BIT] || clr))
            status <= next_word;
        else if (clr)
            status <= '0;
    end

    // R8: a valid word is held while no clear arrives.
    p_first_err_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ES_VALID_BIT] && !clr) |=> (status == $past(status)));

    // R8: an error seen while not valid makes the word valid.
    p_err_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[ES_VALID_BIT] && any_err) |=> status[ES_VALID_BIT]);

endmodule

// File: rtl/dma_chan_regbank.sv
// Module: dma_chan_regbank (top)
// Control and status register bank of a DMA engine with up to 64
// channels. Decodes word writes, byte commands and write-one-to-clear,
// records per-channel events and drives the interrupt and pulse outputs.
// Assumes NUM_CH is between 1 and 64 and events are one-cycle pulses.
module dma_chan_regbank
    import dma_regbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [5:0]        bus_waddr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] ch_done_evt,
    input  logic [NUM_CH-1:0] ch_err_evt,
    input  logic [9:0]        err_info,
    output logic              irq_done,
    output logic              irq_err,
    output logic [NUM_CH-1:0] req_en,
    output logic [NUM_CH-1:0] ch_start,
    output logic [NUM_CH-1:0] ch_done_clr,
    output logic              ctl_clk_gate_en,
    output logic              ctl_rr_group,
    output logic              ctl_rr_chan
);

    localparam logic [NUM_CH-1:0] NO_BITS = '0;

    logic [N_CMD-1:0][NUM_CH-1:0] cmd_hit;
    logic [31:0]  mask;
    logic [63:0]  req_ld64, eei_ld64, int_w1c64, err_w1c64, wval64;
    logic [NUM_CH-1:0] req_q, eei_q, int_q, err_q;
    logic [NUM_CH-1:0] int_clr, err_clr;
    logic [31:0]  estat;
    logic         estat_clr;
    logic [2:0]   ctl_q;

    dma_cmd_decode #(.NUM_CH(NUM_CH)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .waddr   (bus_waddr),
        .be      (bus_be),
        .wdata   (bus_wdata),
        .cmd_hit (cmd_hit)
    );

    // Purpose: per-bit load and write-one-to-clear masks from word writes.
    always_comb begin
        mask      = lane_mask(bus_be);
        wval64    = {bus_wdata, bus_wdata};
        req_ld64  = {(bus_wr && bus_waddr == 6'(WI_REQ_HI)) ? mask : 32'h0,
                     (bus_wr && bus_waddr == 6'(WI_REQ_LO)) ? mask : 32'h0};
        eei_ld64  = {(bus_wr && bus_waddr == 6'(WI_EEI_HI)) ? mask : 32'h0,
                     (bus_wr && bus_waddr == 6'(WI_EEI_LO)) ? mask : 32'h0};
        int_w1c64 = {(bus_wr && bus_waddr == 6'(WI_INT_HI)) ? (mask & bus_wdata) : 32'h0,
                     (bus_wr && bus_waddr == 6'(WI_INT_LO)) ? (mask & bus_wdata) : 32'h0};
        err_w1c64 = {(bus_wr && bus_waddr == 6'(WI_ERR_HI)) ? (mask & bus_wdata) : 32'h0,
                     (bus_wr && bus_waddr == 6'(WI_ERR_LO)) ? (mask & bus_wdata) : 32'h0};
        int_clr   = int_w1c64[NUM_CH-1:0] | cmd_hit[CMD_CLR_INT];
        err_clr   = err_w1c64[NUM_CH-1:0] | cmd_hit[CMD_CLR_ERR];
        estat_clr = bus_wr && (bus_waddr == 6'(WI_ESTAT)) && bus_be[3] && bus_wdata[ES_VALID_BIT];
    end

    dma_chan_bits #(.W(NUM_CH)) u_req (
        .clk(clk), .rst_n(rst_n),
        .load_en(req_ld64[NUM_CH-1:0]), .load_val(wval64[NUM_CH-1:0]),
        .clr(cmd_hit[CMD_CLR_REQ]), .set(cmd_hit[CMD_SET_REQ]), .q(req_q)
    );

    dma_chan_bits #(.W(NUM_CH)) u_eei (
        .clk(clk), .rst_n(rst_n),
        .load_en(eei_ld64[NUM_CH-1:0]), .load_val(wval64[NUM_CH-1:0]),
        .clr(cmd_hit[CMD_CLR_EEI]), .set(cmd_hit[CMD_SET_EEI]), .q(eei_q)
    );

    dma_chan_bits #(.W(NUM_CH)) u_int (
        .clk(clk), .rst_n(rst_n),
        .load_en(NO_BITS), .load_val(NO_BITS),
        .clr(int_clr), .set(ch_done_evt), .q(int_q)
    );

    dma_chan_bits #(.W(NUM_CH)) u_err (
        .clk(clk), .rst_n(rst_n),
        .load_en(NO_BITS), .load_val(NO_BITS),
        .clr(err_clr), .set(ch_err_evt), .q(err_q)
    );

    dma_err_capture #(.NUM_CH(NUM_CH)) u_estat (
        .clk(clk), .rst_n(rst_n),
        .err_evt(ch_err_evt), .info(err_info),
        .clr(estat_clr), .status(estat)
    );

    // Purpose: control word storage, byte lanes 3 and 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (bus_wr && bus_waddr == 6'(WI_CTRL)) begin
            if (bus_be[3]) ctl_q[2] <= bus_wdata[CTL_CLKGATE_BIT];
            if (bus_be[0]) ctl_q[1:0] <= bus_wdata[CTL_RRGRP_BIT:CTL_RRCH_BIT];
        end
    end

    // Purpose: one-cycle start and done-clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_start    <= '0;
            ch_done_clr <= '0;
        end else begin
            ch_start    <= cmd_hit[CMD_SET_START];
            ch_done_clr <= cmd_hit[CMD_CLR_DONE];
        end
    end

    // Purpose: combinational read mux over the word map.
    always_comb begin
        unique case (bus_waddr)
            6'(WI_CTRL):   bus_rdata = {ctl_q[2], 27'h0, ctl_q[1:0], 2'b00};
            6'(WI_ESTAT):  bus_rdata = estat;
            6'(WI_REQ_HI): bus_rdata = half_of(64'(req_q), 1'b1);
            6'(WI_REQ_LO): bus_rdata = half_of(64'(req_q), 1'b0);
            6'(WI_EEI_HI): bus_rdata = half_of(64'(eei_q), 1'b1);
            6'(WI_EEI_LO): bus_rdata = half_of(64'(eei_q), 1'b0);
            6'(WI_INT_HI): bus_rdata = half_of(64'(int_q), 1'b1);
            6'(WI_INT_LO): bus_rdata = half_of(64'(int_q), 1'b0);
            6'(WI_ERR_HI): bus_rdata = half_of(64'(err_q), 1'b1);
            6'(WI_ERR_LO): bus_rdata = half_of(64'(err_q), 1'b0);
            default:       bus_rdata = 32'h0;
        endcase
    end

    // Purpose: interrupt and control outputs.
    always_comb begin
        irq_done        = |int_q;
        irq_err         = |(err_q & eei_q);
        req_en          = req_q;
        ctl_clk_gate_en = ctl_q[2];
        ctl_rr_group    = ctl_q[1];
        ctl_rr_chan     = ctl_q[0];
    end

    // R5: the done interrupt only rises after a completion event.
    p_irq_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_done) |-> $past(|ch_done_evt));

    // R10: at most one channel starts per cycle.
    p_start_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_start));

    // R11: reserved word indices read zero.
    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_waddr >= 6'd12) |-> (bus_rdata == 32'h0));

    // R12: a full low-word write of request enables reaches req_en.
    p_req_lo_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_waddr == 6'(WI_REQ_LO) && bus_be == 4'hF)
        |=> (req_en[31:0] == $past(bus_wdata)));

endmodule

// File: tb/tb_dma_chan_regbank.sv
// Bench for dma_chan_regbank: table of write/readback vectors, then
// directed tests for reset, events, error capture and pulses.
module tb_dma_chan_regbank;

    localparam int unsigned NCH      = 64;
    localparam time         CLK_PER  = 10ns;
    localparam int unsigned N_VEC    = 14;

    // Entry: {write index, strobes, write data, read index, expected}.
    localparam logic [79:0] VEC [N_VEC] = '{
        {6'd0,  4'hF, 32'hFFFF_FFFF, 6'd0,  32'h8000_000C},   // R2 control
        {6'd3,  4'hF, 32'hA5A5_A5A5, 6'd3,  32'hA5A5_A5A5},   // R2 req lo
        {6'd3,  4'h1, 32'h0000_00FF, 6'd3,  32'hA5A5_A5FF},   // R2 byte strobe
        {6'd2,  4'hF, 32'h1234_5678, 6'd2,  32'h1234_5678},   // R2 req hi
        {6'd5,  4'hF, 32'h0000_FFFF, 6'd5,  32'h0000_FFFF},   // R2 eei lo
        {6'd4,  4'hF, 32'hFFFF_0000, 6'd4,  32'hFFFF_0000},   // R2 eei hi
        {6'd6,  4'h1, 32'h0000_0021, 6'd2,  32'h1234_567A},   // R3 set req 33
        {6'd6,  4'h2, 32'h0000_0400, 6'd3,  32'hA5A5_A5EF},   // R3 clr req 4
        {6'd6,  4'h4, 32'h0014_0000, 6'd5,  32'h0010_FFFF},   // R3 set eei 20
        {6'd6,  4'h8, 32'h3F00_0000, 6'd4,  32'h7FFF_0000},   // R3 clr eei 63
        {6'd6,  4'h1, 32'h0000_0040, 6'd3,  32'hA5A5_A5EF},   // R4 bit6 ignored
        {6'd6,  4'h1, 32'h0000_0080, 6'd2,  32'h1234_567A},   // R4 bit7 ignored
        {6'd12, 4'hF, 32'hFFFF_FFFF, 6'd12, 32'h0000_0000},   // R11 reserved
        {6'd7,  4'h0, 32'h0000_0000, 6'd6,  32'h0000_0000}    // R11 cmd word
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [5:0]      bus_waddr = '0;
    logic [3:0]      bus_be = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  ch_done_evt = '0;
    logic [NCH-1:0]  ch_err_evt = '0;
    logic [9:0]      err_info = '0;
    logic            irq_done, irq_err;
    logic [NCH-1:0]  req_en, ch_start, ch_done_clr;
    logic            ctl_clk_gate_en, ctl_rr_group, ctl_rr_chan;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PER/2) clk = ~clk;

    dma_chan_regbank #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_done_evt(ch_done_evt), .ch_err_evt(ch_err_evt), .err_info(err_info),
        .irq_done(irq_done), .irq_err(irq_err), .req_en(req_en),
        .ch_start(ch_start), .ch_done_clr(ch_done_clr),
        .ctl_clk_gate_en(ctl_clk_gate_en), .ctl_rr_group(ctl_rr_group),
        .ctl_rr_chan(ctl_rr_chan)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        bus_waddr = a;
        #1;
        chk(tag, {32'h0, bus_rdata}, {32'h0, exp});
    endtask

    task automatic pulse(input logic [NCH-1:0] d, input logic [NCH-1:0] e, input logic [9:0] info);
        @(negedge clk);
        ch_done_evt = d; ch_err_evt = e; err_info = info;
        @(negedge clk);
        ch_done_evt = '0; ch_err_evt = '0; err_info = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 12; i++) rd("R1 reset word", 6'(i), 32'h0);
        chk("R1 irq outputs", {62'h0, irq_done, irq_err}, 64'h0);
        chk("R1 pulses", ch_start | ch_done_clr | req_en, 64'h0);

        // Table walk: write, then read back.
        for (int v = 0; v < N_VEC; v++) begin
            wr(VEC[v][79:74], VEC[v][73:70], VEC[v][69:38]);
            rd($sformatf("table vector %0d", v), VEC[v][37:32], VEC[v][31:0]);
        end
        chk("R2 control outputs", {61'h0, ctl_clk_gate_en, ctl_rr_group, ctl_rr_chan}, 64'h7);
        chk("R12 req_en mirror", req_en, 64'h1234_567A_A5A5_A5EF);

        // R5: done events and clears
        pulse((64'h1 << 3) | (64'h1 << 40), '0, '0);
        rd("R5 int lo", 6'd9, 32'h8);
        rd("R5 int hi", 6'd8, 32'h100);
        chk("R5 irq_done set", {63'h0, irq_done}, 64'h1);
        wr(6'd7, 4'h1, 32'h0000_0003);
        rd("R5 clr cmd int lo", 6'd9, 32'h0);
        wr(6'd8, 4'hF, 32'hFFFF_FFFF);
        rd("R5 w1c int hi", 6'd8, 32'h0);
        chk("R5 irq_done clear", {63'h0, irq_done}, 64'h0);

        // R8/R9: first error captured; ch40 not enabled for interrupt.
        pulse('0, 64'h1 << 40, 10'b10_1000_0001);
        rd("R6 err hi", 6'd10, 32'h100);
        rd("R8 first status", 6'd1, 32'h8000_A881);
        chk("R9 irq_err masked", {63'h0, irq_err}, 64'h0);
        pulse('0, 64'h1 << 2, 10'b00_0000_0100);
        rd("R8 first kept", 6'd1, 32'h8000_A881);
        chk("R9 irq_err enabled", {63'h0, irq_err}, 64'h1);
        wr(6'd1, 4'h8, 32'h8000_0000);
        rd("R8 status cleared", 6'd1, 32'h0);
        pulse('0, (64'h1 << 5) | (64'h1 << 9), 10'b01_0001_0000);
        rd("R8 lowest channel", 6'd1, 32'h8000_4510);
        rd("R6 err lo", 6'd11, 32'h224);
        wr(6'd7, 4'h2, 32'h0000_0200);
        rd("R6 clr cmd", 6'd11, 32'h220);
        wr(6'd11, 4'hF, 32'h0000_0020);
        rd("R6 w1c single", 6'd11, 32'h200);
        wr(6'd11, 4'hF, 32'hFFFF_FFFF);
        rd("R6 w1c all", 6'd11, 32'h0);
        chk("R9 irq_err off", {63'h0, irq_err}, 64'h0);

        // R7: set event and clear command on the same bit, same cycle.
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = 6'd7; bus_be = 4'h1; bus_wdata = 32'h7;
        ch_done_evt = 64'h1 << 7;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0; ch_done_evt = '0;
        rd("R7 set beats clr cmd", 6'd9, 32'h80);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = 6'd9; bus_be = 4'hF; bus_wdata = 32'hFFFF_FFFF;
        ch_done_evt = 64'h1 << 7;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0; ch_done_evt = '0;
        rd("R7 set beats w1c", 6'd9, 32'h80);
        wr(6'd9, 4'hF, 32'hFFFF_FFFF);

        // R10: start and done-clear pulses, one cycle wide.
        wr(6'd7, 4'h4, 32'h002A_0000);
        chk("R10 start pulse", ch_start, 64'h1 << 42);
        @(negedge clk);
        chk("R10 start ends", ch_start, 64'h0);
        wr(6'd7, 4'h8, 32'h3F00_0000);
        chk("R10 done clr pulse", ch_done_clr, 64'h1 << 63);
        wr(6'd7, 4'h4, 32'h0045_0000);
        chk("R4 start ignored", ch_start, 64'h0);
        rd("R11 cmd word b", 6'd7, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule